// File: doc/BRIEF.md
# Write-Only Bit-Banged I2C Master with Asymmetric Settle Timing

This block performs I2C write transactions on a pair of open-drain lines. A command supplies a 7-bit target address and a count of data bytes. The block sends the address byte with the write direction, then takes the data bytes one by one from a valid/ready byte stream and sends each of them, and raises a one-cycle `done` when the bus has been left released.

Every change on a line is a separate step. After each step the block waits a settle interval before the next step. The interval is long when the step released a line to high and short when it pulled a line low. Both intervals are parameters counted in clock cycles. The block has no input from the lines. Each acknowledge slot is clocked with SDA released, and the block always treats it as accepted. Every transaction opens with a full stop sequence and then a start sequence, so a bus left in an unknown state is brought back to a known one first.

The byte stream follows valid/ready rules. A byte is taken on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high only while the block is waiting for the next data byte. During that wait the bus lines are frozen, so a slow producer stretches the SCL-high phase that follows the previous acknowledge. While `in_ready` is low, `in_data` and `in_valid` are ignored.

Top module: `i2cw_master`

## Requirements
- R1: During and directly after reset both pull outputs are 0 (lines released), and `busy`, `done` and `in_ready` are 0.
- R2: `cmd_start` is accepted only while `busy` is 0, and `busy` is 1 in the cycle after acceptance. A `cmd_start` while busy is ignored and leaves the transaction in flight unchanged.
- R3: A transaction opens with SCL falling, SDA falling, SCL rising (SDA low), and SDA rising, which is a stop condition. This is followed by SDA falling while SCL is high, which is a start condition.
- R4: The first byte on the bus is `{cmd_addr, 1'b0}` (bit 0 = 0 means write). It is sent MSB first, and each bit is the SDA level at an SCL rising edge.
- R5: Outside the opening and closing sequences, SDA changes only while SCL is low. Each bit is sent as SCL low, then SDA set, then SCL high.
- R6: After every byte there is one acknowledge clock during which SDA is released (reads 1). The transaction continues no matter what the line would show.
- R7: Exactly `cmd_len` data bytes follow the address, in stream order and MSB first. With `cmd_len` = 0 only the address byte is sent.
- R8: `in_ready` is 1 only while busy and waiting for a byte. Neither line changes while `in_ready` stays 1, and `in_data`/`in_valid` have no effect while `in_ready` is 0.
- R9: After a step that drives a line high, the next step comes `SETTLE_HI_CYC`+1 cycles later. After a step that drives a line low, the next step comes `SETTLE_LO_CYC`+1 cycles later. So a bit's SCL-high time is `SETTLE_HI_CYC`+1 cycles, and SCL falls `SETTLE_LO_CYC`+1 cycles after the start condition.
- R10: No two line changes happen in the same cycle.
- R11: `done` is a single-cycle pulse, once per transaction, `SETTLE_HI_CYC`+1 cycles after the final SDA rise. `busy` is 0 in that cycle.
- R12: A transaction ends with SCL rising while SDA is low and then SDA rising (stop), and both lines stay released while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Begin a transaction (taken only when idle) |
| cmd_addr | input | 7 | 7-bit target address |
| cmd_len | input | LEN_W | Number of data bytes to send |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| in_data | input | 8 | Next data byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Block will take a byte this cycle |
| scl_pull | output | 1 | Open-drain enable for SCL; 1 pulls the line low |
| sda_pull | output | 1 | Open-drain enable for SDA; 1 pulls the line low |

## Verification
The assertions check several properties on every cycle. They check that only one line moves at a time, that SDA moves only under a low SCL while bits and acknowledges are being sent, and that the lines hold still while a byte is awaited. They also check that the settle counter counts down cleanly, that `done` is a lone pulse outside `busy`, and that an idle block leaves both lines released. The bench's scenarios are needed for the bus-level content. They decode the stop/start symbols and the bits on SCL rising edges and compare them with the expected address, data and acknowledge sequence. They also measure the high-time and start-to-clock settle intervals, the `done` latency, stalls of the byte stream, commands ignored while busy, and a reset that cuts a transaction short.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  localparam int unsigned ADDR_BITS = 7;
  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE_STOP,
    PH_START,
    PH_BITS,
    PH_ACK,
    PH_LOAD,
    PH_END_STOP,
    PH_FINISH
  } phase_e;

  typedef enum logic {
    LN_SCL = 1'b0,
    LN_SDA = 1'b1
  } line_e;

  typedef struct packed {
    line_e line;
    logic  level;
  } line_step_t;

  typedef struct packed {
    logic       fire;
    line_step_t step;
  } line_op_t;

  // Stop sequence: clock low, data low, clock high, data high.
  function automatic line_step_t stop_step(input logic [1:0] idx);
    line_step_t s;
    case (idx)
      2'd0:    s = '{line: LN_SCL, level: 1'b0};
      2'd1:    s = '{line: LN_SDA, level: 1'b0};
      2'd2:    s = '{line: LN_SCL, level: 1'b1};
      default: s = '{line: LN_SDA, level: 1'b1};
    endcase
    return s;
  endfunction

  // Start sequence: clock high, data high, data low.
  function automatic line_step_t start_step(input logic [1:0] idx);
    line_step_t s;
    case (idx)
      2'd0:    s = '{line: LN_SCL, level: 1'b1};
      2'd1:    s = '{line: LN_SDA, level: 1'b1};
      default: s = '{line: LN_SDA, level: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/i2cw_settle_timer.sv
module i2cw_settle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  // R9: a load sets the count, then it steps down by one each cycle
  p_load_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  p_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/i2cw_byte_shifter.sv
module i2cw_byte_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb,
  output logic         last
);

  localparam int unsigned IDX_W = (W < 2) ? 1 : $clog2(W);

  logic [W-1:0]     sh_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_val;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign msb  = sh_q[W-1];
  assign last = (idx_q == IDX_W'(W - 1));

  // R4: bits leave most significant first
  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (sh_q[W-1] == $past(sh_q[W-2])));

endmodule

// File: rtl/i2cw_line_driver.sv
module i2cw_line_driver
  import i2cw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  line_op_t op,
  output logic     scl_level,
  output logic     sda_level,
  output logic     scl_pull,
  output logic     sda_pull
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (op.fire) begin
      if (op.step.line == LN_SCL) begin
        scl_q <= op.step.level;
      end else begin
        sda_q <= op.step.level;
      end
    end
  end

  assign scl_level = scl_q;
  assign sda_level = sda_q;
  // open drain: an asserted enable pulls the line low
  assign scl_pull  = ~scl_q;
  assign sda_pull  = ~sda_q;

  // R10: never both lines in the same cycle
  p_one_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(scl_q) && !$stable(sda_q)));

endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
  import i2cw_pkg::*;
#(
  parameter int unsigned SETTLE_HI_CYC = 200000,
  parameter int unsigned SETTLE_LO_CYC = 2000,
  parameter int unsigned LEN_W         = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_start,
  input  logic [ADDR_BITS-1:0] cmd_addr,
  input  logic [LEN_W-1:0]     cmd_len,
  output logic                 busy,
  output logic                 done,
  input  logic [BYTE_BITS-1:0] in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 scl_pull,
  output logic                 sda_pull
);

  localparam int unsigned MAX_SETTLE = (SETTLE_HI_CYC > SETTLE_LO_CYC) ? SETTLE_HI_CYC : SETTLE_LO_CYC;
  localparam int unsigned CNT_W      = (MAX_SETTLE < 1) ? 1 : $clog2(MAX_SETTLE + 1);
  localparam logic [CNT_W-1:0] HI_LOAD = CNT_W'(SETTLE_HI_CYC);
  localparam logic [CNT_W-1:0] LO_LOAD = CNT_W'(SETTLE_LO_CYC);

  phase_e                 state_q;
  logic [1:0]             stp_q;
  logic [LEN_W-1:0]       left_q;
  logic                   done_q;

  logic                   tmr_busy;
  logic                   stepping;
  logic                   issue;
  logic                   step_last;
  line_op_t               op;
  logic [CNT_W-1:0]       tmr_val;

  logic                   sh_load;
  logic                   sh_shift;
  logic [BYTE_BITS-1:0]   sh_val;
  logic                   sh_msb;
  logic                   sh_last;

  logic                   scl_level;
  logic                   sda_level;

  // ---------------------------------------------------------------
  // Step generation
  // ---------------------------------------------------------------
  always_comb begin
    stepping = (state_q == PH_PRE_STOP) || (state_q == PH_START) ||
               (state_q == PH_BITS)     || (state_q == PH_ACK)   ||
               (state_q == PH_END_STOP);
  end

  assign issue = stepping && !tmr_busy;

  always_comb begin
    op.fire   = issue;
    op.step   = '{line: LN_SCL, level: 1'b1};
    step_last = 1'b0;
    case (state_q)
      PH_PRE_STOP, PH_END_STOP: begin
        op.step   = stop_step(stp_q);
        step_last = (stp_q == 2'd3);
      end
      PH_START: begin
        op.step   = start_step(stp_q);
        step_last = (stp_q == 2'd2);
      end
      PH_BITS: begin
        op.step.line  = (stp_q == 2'd1) ? LN_SDA : LN_SCL;
        op.step.level = (stp_q == 2'd0) ? 1'b0 : ((stp_q == 2'd1) ? sh_msb : 1'b1);
        step_last     = (stp_q == 2'd2);
      end
      PH_ACK: begin
        // SDA released during the slot; the answer is never examined
        op.step.line  = (stp_q == 2'd1) ? LN_SDA : LN_SCL;
        op.step.level = (stp_q != 2'd0);
        step_last     = (stp_q == 2'd2);
      end
      default: begin
      end
    endcase
  end

  // long settle after driving high, short after driving low
  assign tmr_val = op.step.level ? HI_LOAD : LO_LOAD;

  // ---------------------------------------------------------------
  // Sequencer
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      stp_q   <= 2'd0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        PH_IDLE: begin
          if (cmd_start) begin
            state_q <= PH_PRE_STOP;
            stp_q   <= 2'd0;
            left_q  <= cmd_len;
          end
        end
        PH_LOAD: begin
          if (in_valid) begin
            state_q <= PH_BITS;
            stp_q   <= 2'd0;
            left_q  <= left_q - 1'b1;
          end
        end
        PH_FINISH: begin
          if (!tmr_busy) begin
            state_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: begin
          if (issue) begin
            if (!step_last) begin
              stp_q <= stp_q + 1'b1;
            end else begin
              stp_q <= 2'd0;
              case (state_q)
                PH_PRE_STOP: state_q <= PH_START;
                PH_START:    state_q <= PH_BITS;
                PH_BITS:     state_q <= sh_last ? PH_ACK : PH_BITS;
                PH_ACK:      state_q <= (left_q != '0) ? PH_LOAD : PH_END_STOP;
                default:     state_q <= PH_FINISH;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign sh_load  = ((state_q == PH_IDLE) && cmd_start) || ((state_q == PH_LOAD) && in_valid);
  assign sh_val   = (state_q == PH_IDLE) ? {cmd_addr, 1'b0} : in_data;
  assign sh_shift = issue && (state_q == PH_BITS) && (stp_q == 2'd2);

  assign busy     = (state_q != PH_IDLE);
  assign done     = done_q;
  assign in_ready = (state_q == PH_LOAD);

  // ---------------------------------------------------------------
  // Sub-blocks
  // ---------------------------------------------------------------
  i2cw_settle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue),
    .load_val (tmr_val),
    .busy     (tmr_busy)
  );

  i2cw_byte_shifter #(
    .W (BYTE_BITS)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift    (sh_shift),
    .msb      (sh_msb),
    .last     (sh_last)
  );

  i2cw_line_driver u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .scl_level (scl_level),
    .sda_level (sda_level),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull)
  );

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  p_ready_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  p_hold_in_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_LOAD) && $past(state_q == PH_LOAD)) |-> ($stable(scl_level) && $stable(sda_level)));

  p_sda_under_low_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_level) && $past((state_q == PH_BITS) || (state_q == PH_ACK))) |-> !scl_level);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE) |-> (scl_level && sda_level));

  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((state_q != PH_PRE_STOP) || ($past(state_q) == PH_PRE_STOP)));

endmodule

// File: tb/i2cw_master_tb.sv
`timescale 1ns/100ps
module i2cw_master_tb_top;

  localparam int HI  = 6;
  localparam int LO  = 2;
  localparam int LW  = 4;
  localparam logic [1:0] SYM_P = 2'd2;
  localparam logic [1:0] SYM_S = 2'd3;

  // {addr[45:39], len[38:36], byte0..byte3[35:4], gap[3:0]}
  localparam int NV = 5;
  localparam logic [45:0] VECS [NV] = '{
    {7'h50, 3'd1, 32'hA5000000, 4'd0},
    {7'h2B, 3'd3, 32'h00FF3C00, 4'd0},
    {7'h7F, 3'd0, 32'h00000000, 4'd0},
    {7'h01, 3'd4, 32'h817E55AA, 4'd3},
    {7'h00, 3'd2, 32'h01800000, 4'd9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic busy, done;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic scl_pull, sda_pull;

  always #2.5 clk = ~clk;

  i2cw_master #(
    .SETTLE_HI_CYC (HI),
    .SETTLE_LO_CYC (LO),
    .LEN_W         (LW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .cmd_start (cmd_start), .cmd_addr (cmd_addr), .cmd_len (cmd_len),
    .busy (busy), .done (done),
    .in_data (in_data), .in_valid (in_valid), .in_ready (in_ready),
    .scl_pull (scl_pull), .sda_pull (sda_pull)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- bus monitor (samples on falling clock) ----------
  logic [1:0] sym [0:63];
  int nsym = 0;
  int hi_bad = 0, start_bad = 0, hold_bad = 0, ready_bad = 0, both_bad = 0;
  int done_cnt = 0, done_gap = 0;
  int rise_t = 0, start_t = 0, stop_t = 0;
  bit sda_moved = 1'b1, start_seen = 1'b0, stalled = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1, p_ready = 1'b0;

  task automatic push(input logic [1:0] s);
    if (nsym < 64) sym[nsym] = s;
    nsym++;
  endtask

  always @(negedge clk) begin
    logic scl, sda;
    scl = !scl_pull;
    sda = !sda_pull;
    if (!rst_n) begin
      sda_moved  = 1'b1;
      start_seen = 1'b0;
      p_ready    = 1'b0;
    end else begin
      if (in_ready && !busy) ready_bad++;
      if (in_ready) stalled = 1'b1;
      if (p_ready && in_ready && (scl != p_scl || sda != p_sda)) hold_bad++;
      if (scl != p_scl && sda != p_sda) both_bad++;
      if (scl && !p_scl) begin
        push({1'b0, sda});
        rise_t = cyc; sda_moved = 1'b0; stalled = in_ready;
      end else if (!scl && p_scl) begin
        if (!sda_moved && !stalled && (cyc - rise_t) != HI + 1) hi_bad++;
        if (start_seen) begin
          if ((cyc - start_t) != LO + 1) start_bad++;
          start_seen = 1'b0;
        end
      end else if (scl && p_scl && sda != p_sda) begin
        sda_moved = 1'b1;
        if (sda) begin push(SYM_P); stop_t = cyc; end
        else begin push(SYM_S); start_t = cyc; start_seen = 1'b1; end
      end
      if (done) begin done_cnt++; done_gap = cyc - stop_t; end
      p_ready = in_ready;
    end
    p_scl = scl;
    p_sda = sda;
  end

  // ---------------- helpers -------------------------------------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nsym = 0; hi_bad = 0; start_bad = 0; hold_bad = 0; ready_bad = 0; both_bad = 0;
  endtask

  task automatic run_txn(input logic [6:0] a, input int len, input logic [31:0] d,
                         input int gap, input bit poke);
    logic [1:0] ex [0:63];
    int tg [0:63];
    int n, m3, m4, m6, m7, m12, d0, waitc;
    logic [7:0] b;
    n = 0;
    ex[n] = 2'd0;  tg[n++] = 3;
    ex[n] = SYM_P; tg[n++] = 3;
    ex[n] = SYM_S; tg[n++] = 3;
    b = {a, 1'b0};
    for (int i = 7; i >= 0; i--) begin ex[n] = {1'b0, b[i]}; tg[n++] = 4; end
    ex[n] = 2'd1; tg[n++] = 6;
    for (int k = 0; k < len; k++) begin
      b = d[31 - 8*k -: 8];
      for (int i = 7; i >= 0; i--) begin ex[n] = {1'b0, b[i]}; tg[n++] = 7; end
      ex[n] = 2'd1; tg[n++] = 6;
    end
    ex[n] = 2'd0;  tg[n++] = 12;
    ex[n] = SYM_P; tg[n++] = 12;

    clear_mon();
    d0 = done_cnt;
    cmd_addr = a; cmd_len = LW'(len); cmd_start = 1'b1;
    tick();
    cmd_start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      for (int i = 0; i < 10; i++) tick();
      cmd_addr = ~a; cmd_len = LW'(3); cmd_start = 1'b1;
      tick();
      cmd_start = 1'b0;
    end
    for (int k = 0; k < len; k++) begin
      if (gap > 0) begin
        waitc = 0;
        while (!in_ready && waitc < 5000) begin tick(); waitc++; end
        for (int g = 0; g < gap; g++) tick();
      end
      in_data = d[31 - 8*k -: 8];
      in_valid = 1'b1;
      waitc = 0;
      while (!in_ready && waitc < 5000) begin tick(); waitc++; end
      tick();
      in_valid = 1'b0;
      in_data = 8'h3C ^ 8'(k);
    end
    waitc = 0;
    while (done_cnt == d0 && waitc < 5000) begin tick(); waitc++; end
    for (int i = 0; i < 4; i++) tick();

    m3 = 0; m4 = 0; m6 = 0; m7 = 0; m12 = 0;
    for (int i = 0; i < n && i < nsym; i++) begin
      if (sym[i] !== ex[i]) begin
        case (tg[i])
          3: m3++; 4: m4++; 6: m6++; 7: m7++; default: m12++;
        endcase
      end
    end
    check(nsym == n, "R7 symbol count", nsym, n);
    check(m3 == 0, "R3 opening stop+start", m3, 0);
    check(m4 == 0, "R4 address byte", m4, 0);
    check(m6 == 0, "R6 ack slots", m6, 0);
    if (len > 0) check(m7 == 0, "R7 data bytes", m7, 0);
    check(m12 == 0, "R12 closing stop", m12, 0);
    check(hi_bad == 0, "R9 SCL high time", hi_bad, 0);
    check(start_bad == 0, "R9 start to SCL fall", start_bad, 0);
    check(both_bad == 0, "R10 one line per step", both_bad, 0);
    check(hold_bad == 0 && ready_bad == 0, "R8 stream hold", hold_bad + ready_bad, 0);
    check(done_cnt - d0 == 1, "R11 done count", done_cnt - d0, 1);
    check(done_gap == HI + 1, "R11 done latency", done_gap, HI + 1);
    check(scl_pull == 1'b0 && sda_pull == 1'b0 && !busy, "R12 released after",
          int'({scl_pull, sda_pull, busy}), 0);
  endtask

  // ---------------- watchdog ------------------------------------------
  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main sequence -------------------------------------
  initial begin
    for (int i = 0; i < 3; i++) tick();
    // R1 reset state
    check(scl_pull == 0 && sda_pull == 0, "R1 lines released in reset", int'({scl_pull, sda_pull}), 0);
    check(!busy && !done && !in_ready, "R1 flags low in reset", int'({busy, done, in_ready}), 0);
    rst_n = 1'b1;
    tick();
    check(!busy && !done && !in_ready && !scl_pull && !sda_pull, "R1 state after reset",
          int'({busy, done, in_ready, scl_pull, sda_pull}), 0);

    // R8 stream ignored while idle
    in_valid = 1'b1; in_data = 8'hEE;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(!in_ready && !scl_pull && !sda_pull, "R8 idle ignores stream",
            int'({in_ready, scl_pull, sda_pull}), 0);
    end
    in_valid = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_txn(VECS[v][45:39], int'(VECS[v][38:36]), VECS[v][35:4], int'(VECS[v][3:0]), 1'b0);
    end

    // R2 start while busy ignored
    run_txn(7'h3A, 1, 32'hC3000000, 0, 1'b1);

    // R1 reset cutting a transaction short
    cmd_addr = 7'h11; cmd_len = LW'(2); cmd_start = 1'b1;
    tick();
    cmd_start = 1'b0;
    for (int i = 0; i < 30; i++) tick();
    rst_n = 1'b0;
    tick();
    check(!scl_pull && !sda_pull && !busy && !in_ready, "R1 mid-transfer reset",
          int'({scl_pull, sda_pull, busy, in_ready}), 0);
    tick();
    rst_n = 1'b1;
    tick();
    run_txn(7'h6C, 2, 32'h5AA50000, 2, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule